// File: doc/BRIEF.md
# Five-Level Phase-Disposition PWM Modulator

This block turns a numerically generated sine reference into gate commands for a single-phase inverter. The inverter has five output levels and three half-bridge legs. Each leg has an A-side gate and a B-side gate that are driven as a complementary pair. A 32-bit line-phase accumulator addresses a computed quarter-wave sine table, and the table value is scaled by a modulation word. A second 32-bit accumulator produces a triangular carrier. That carrier is used twice: once as a lower carrier and once lifted by one full carrier span as an upper carrier. The reference magnitude is compared against both carriers, which sets the level magnitude. The sign of the line phase sets the polarity.

Leg 2 follows only the polarity, so it switches at line rate. Legs 1 and 3 carry the carrier-rate switching. The half levels swap their active leg on alternate carrier periods, which spreads switching wear between the two legs. Every gate turn-on is held back by a programmable dead time. After reset, all gates stay off until one full carrier period has passed.

All inputs are plain control words that are sampled every clock. There is no stream interface and no handshake, so the block never applies back-pressure and never waits on its consumer. Typical settings are a modulation word of 22938 (0.7 of full scale), a line frequency of 60 Hz and a carrier frequency of 1.8 kHz. Each step word is the desired frequency times 2^32 divided by the clock rate.

Top module: `penta_pwm_top`

## Requirements
- R1: Each clock, both accumulators add their step word modulo 2^32. The reference magnitude is floor(mod_index*Q/2^15). Q is taken from the table T(i) = floor(32767*16*i*(512-i)/(1310720-4*i*(512-i))) for i = 0..255. The table is addressed with line-phase bits [29:22], and that address is inverted when bit 30 is set. A modulation word of 0.7 full scale must reach both +2 and -2 within one line period.
- R2: The lower carrier is carrier-phase bits [30:17], inverted when bit 31 is set, giving a range of 0..16383. The upper carrier is the lower carrier plus 16384. The level magnitude is the number of carriers that the reference magnitude strictly exceeds. A reference magnitude below 16384 never yields a magnitude of 2.
- R3: level_code appears one clock after the accumulator state it comes from. It is a 3-bit two's-complement value: 010 = +2, 001 = +1, 000 = 0, 111 = -1, 110 = -2. The sign comes from line-phase bit 31 (0 = positive), and a magnitude of 0 always codes 000.
- R4: Leg 2 requests its A side exactly when line-phase bit 31 is 0. Its gates therefore make exactly two transitions per line period.
- R5: At +2, leg 2 is on A and legs 1 and 3 are on B. At -2, leg 2 is on B and legs 1 and 3 are on A.
- R6: At +1, leg 2 is on A, and the pattern alternates between two forms: leg 1 on B with leg 3 on A, and leg 1 on A with leg 3 on B. At -1, leg 2 is on B, and the pattern alternates between leg 1 on A with leg 3 on B, and leg 1 on B with leg 3 on A. The first form is used before the first carrier wrap after reset, and the choice toggles one clock after each wrap.
- R7: At level 0, legs 1 and 3 both sit on the side opposite to their ±2 position. That is A for positive polarity and B for negative polarity, which shorts the load.
- R8: When a leg's requested side changes, both of its gates turn off. The newly requested gate turns on dead_cycles clocks after the gates would have switched with zero dead time. A change that arrives while the delay is still counting restarts the delay.
- R9: The A and B gates of a leg are never on in the same cycle.
- R10: A synchronous active-high reset clears every gate and level_code. After reset is released, all gates stay off until two clocks after the first carrier-accumulator wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mod_index | input | 15 | Reference amplitude, unsigned fraction of full scale |
| line_step | input | 32 | Line-phase increment per clock |
| carrier_step | input | 32 | Carrier-phase increment per clock |
| dead_cycles | input | 8 | Turn-on delay in clocks (0..255) |
| gate_a | output | 3 | A-side gates, bit k = leg k+1 |
| gate_b | output | 3 | B-side gates, bit k = leg k+1 |
| level_code | output | 3 | Commanded output level, two's complement |

## Verification
The bench targets several corner cases:
- **Pre-arm window.** A block that released its gates straight out of reset would drive the bridge with a partial first carrier period.
- **Redundant half-level alternation.** A decoder stuck on one form would wear one leg twice as fast. The bench sees this as a missing pattern.
- **Small reference.** A reference that never reaches the upper carrier must never produce ±2.
- **Zero modulation.** With the modulation word at zero, the output must sit on the zero-level pattern.
- **Line-rate leg.** Exactly two transitions are expected per line period. An extra edge would show that carrier-rate logic had leaked into the line-rate leg.
- **Dead time at both extremes.** With zero dead time, the gates must swap on the same edge. A wrong count or a missed restart would either shorten the gap, which risks shoot-through, or lengthen it and distort the level.

The stimulus uses both power-of-two and odd step words, so the carrier wrap point does not always fall on an exact boundary.

// File: rtl/penta_pwm_pkg.sv
package penta_pwm_pkg;

  typedef enum logic [2:0] {
    LV_Z  = 3'b000,
    LV_P1 = 3'b001,
    LV_P2 = 3'b010,
    LV_N1 = 3'b111,
    LV_N2 = 3'b110
  } lvl_e;

  // Quarter-wave sine sample i of a table with tn entries, peak fs,
  // from a rational approximation of sin over a half wave of 2*tn steps.
  function automatic int quarter_sine(int i, int tn, int fs);
    longint h;
    longint p;
    h = 2 * longint'(tn);
    p = longint'(i) * (h - longint'(i));
    return int'((longint'(fs) * 16 * p) / (5 * h * h - 4 * p));
  endfunction

endpackage

// File: rtl/penta_nco.sv
module penta_nco #(
  parameter int W  = 32,
  parameter int OW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  step,
  output logic [OW-1:0] top_bits,
  output logic          wrap
);
  logic [W-1:0] acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc  <= '0;
      wrap <= 1'b0;
    end else begin
      {wrap, acc} <= {1'b0, acc} + {1'b0, step};
    end
  end

  assign top_bits = acc[W-1 -: OW];

endmodule

// File: rtl/penta_sine_ref.sv
module penta_sine_ref
  import penta_pwm_pkg::*;
#(
  parameter int DW  = 16,
  parameter int TAW = 8
) (
  input  logic [TAW+1:0] phase_top,
  input  logic [DW-2:0]  mod_index,
  output logic [DW-1:0]  mag,
  output logic           pos
);
  localparam int TN = 1 << TAW;
  localparam int FS = (1 << (DW - 1)) - 1;
  localparam int PW = 2 * DW - 1;

  logic [DW-1:0]  qtab [TN];
  logic [TAW-1:0] addr;
  logic [DW-1:0]  q;
  logic [PW-1:0]  prod;

  for (genvar i = 0; i < TN; i++) begin : g_tab
    assign qtab[i] = DW'(quarter_sine(i, TN, FS));
  end

  // Second and fourth quadrants read the table backwards.
  assign addr = phase_top[TAW] ? ~phase_top[TAW-1:0] : phase_top[TAW-1:0];
  assign q    = qtab[addr];
  assign prod = PW'(mod_index) * PW'(q);
  assign mag  = DW'(prod >> (DW - 1));
  assign pos  = ~phase_top[TAW+1];

endmodule

// File: rtl/penta_level_dec.sv
module penta_level_dec
  import penta_pwm_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-2:0] car_top,
  input  logic          wrap,
  input  logic [DW-1:0] mag,
  input  logic          pos,
  output lvl_e          level,
  output logic [2:0]    leg_a,
  output logic          armed
);
  localparam int CW   = DW - 2;
  localparam int NCAR = 2;

  logic [CW-1:0]   tri_w;
  logic [DW-1:0]   carrier [NCAR];
  logic [NCAR-1:0] above;
  logic [1:0]      mag_lvl;
  logic            alt;
  logic            tow1, tow3;
  lvl_e            level_n;
  logic [2:0]      leg_a_n;

  assign tri_w = car_top[CW] ? ~car_top[CW-1:0] : car_top[CW-1:0];

  // Level-shifted carriers: carrier k sits k spans above the base.
  for (genvar k = 0; k < NCAR; k++) begin : g_car
    localparam logic [DW-1:0] OFS = DW'(k) << CW;
    assign carrier[k] = OFS + DW'(tri_w);
    assign above[k]   = mag > carrier[k];
  end

  assign mag_lvl = 2'($countones(above));

  always_comb begin
    tow1 = (mag_lvl == 2'd2) || ((mag_lvl == 2'd1) && !alt);
    tow3 = (mag_lvl == 2'd2) || ((mag_lvl == 2'd1) &&  alt);
    // Toward the outer level: B side when positive, A side when negative.
    leg_a_n[0] = tow1 ? ~pos : pos;
    leg_a_n[1] = pos;
    leg_a_n[2] = tow3 ? ~pos : pos;
    case (mag_lvl)
      2'd1:    level_n = pos ? LV_P1 : LV_N1;
      2'd2:    level_n = pos ? LV_P2 : LV_N2;
      default: level_n = LV_Z;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      level <= LV_Z;
      leg_a <= '0;
      alt   <= 1'b0;
      armed <= 1'b0;
    end else begin
      level <= level_n;
      leg_a <= leg_a_n;
      alt   <= alt ^ wrap;
      armed <= armed | wrap;
    end
  end

  p_alt_flip_r6: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (alt != $past(alt)));

  p_arm_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    armed |=> armed);

endmodule

// File: rtl/penta_deadtime.sv
module penta_deadtime #(
  parameter int DTW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           want_a,
  input  logic           enable,
  input  logic [DTW-1:0] dead,
  output logic           ga,
  output logic           gb
);
  logic           prev;
  logic           chg;
  logic [DTW-1:0] cnt, cnt_n;

  assign chg   = want_a != prev;
  assign cnt_n = chg ? dead : ((cnt != '0) ? cnt - DTW'(1) : cnt);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev <= 1'b0;
      cnt  <= '0;
      ga   <= 1'b0;
      gb   <= 1'b0;
    end else begin
      prev <= want_a;
      cnt  <= cnt_n;
      ga   <= enable &  want_a & (cnt_n == '0);
      gb   <= enable & ~want_a & (cnt_n == '0);
    end
  end

  p_no_overlap_r9: assert property (@(posedge clk) disable iff (rst)
    !(ga && gb));

  p_gate_follows_want_r8: assert property (@(posedge clk) disable iff (rst)
    (ga |-> $past(want_a)) and (gb |-> !$past(want_a)));

  p_off_when_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !$past(enable) |-> (!ga && !gb));

endmodule

// File: rtl/penta_pwm_top.sv
module penta_pwm_top
  import penta_pwm_pkg::*;
#(
  parameter int PH_W   = 32,
  parameter int DW     = 16,
  parameter int TAB_AW = 8,
  parameter int DT_W   = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [DW-2:0]   mod_index,
  input  logic [PH_W-1:0] line_step,
  input  logic [PH_W-1:0] carrier_step,
  input  logic [DT_W-1:0] dead_cycles,
  output logic [2:0]      gate_a,
  output logic [2:0]      gate_b,
  output logic [2:0]      level_code
);
  localparam int LINE_OW = TAB_AW + 2;
  localparam int CAR_OW  = DW - 1;
  localparam int NLEG    = 3;

  logic [LINE_OW-1:0] line_top;
  logic [CAR_OW-1:0]  car_top;
  logic               line_wrap;
  logic               car_wrap;
  logic [DW-1:0]      mag;
  logic               pos;
  lvl_e               level;
  logic [NLEG-1:0]    leg_a;
  logic               armed;

  penta_nco #(.W(PH_W), .OW(LINE_OW)) u_line_nco (
    .clk(clk), .rst(rst), .step(line_step),
    .top_bits(line_top), .wrap(line_wrap)
  );

  penta_nco #(.W(PH_W), .OW(CAR_OW)) u_car_nco (
    .clk(clk), .rst(rst), .step(carrier_step),
    .top_bits(car_top), .wrap(car_wrap)
  );

  penta_sine_ref #(.DW(DW), .TAW(TAB_AW)) u_ref (
    .phase_top(line_top), .mod_index(mod_index), .mag(mag), .pos(pos)
  );

  penta_level_dec #(.DW(DW)) u_dec (
    .clk(clk), .rst(rst), .car_top(car_top), .wrap(car_wrap),
    .mag(mag), .pos(pos), .level(level), .leg_a(leg_a), .armed(armed)
  );

  for (genvar k = 0; k < NLEG; k++) begin : g_leg
    penta_deadtime #(.DTW(DT_W)) u_dt (
      .clk(clk), .rst(rst), .want_a(leg_a[k]), .enable(armed),
      .dead(dead_cycles), .ga(gate_a[k]), .gb(gate_b[k])
    );
  end

  assign level_code = level;

  p_level_legal_r3: assert property (@(posedge clk) disable iff (rst)
    level_code inside {3'b000, 3'b001, 3'b010, 3'b111, 3'b110});

  p_line_wrap_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    line_wrap |-> !line_top[LINE_OW-1]);

endmodule

// File: tb/penta_pwm_top_tb_top.sv
module penta_pwm_top_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst;
  logic [14:0] mod_index;
  logic [31:0] line_step, carrier_step;
  logic [7:0]  dead_cycles;
  logic [2:0]  gate_a, gate_b, level_code;

  penta_pwm_top dut_i (
    .clk(clk), .rst(rst), .mod_index(mod_index), .line_step(line_step),
    .carrier_step(carrier_step), .dead_cycles(dead_cycles),
    .gate_a(gate_a), .gate_b(gate_b), .level_code(level_code)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // Reference model state
  logic [31:0] m_lph, m_cph;
  bit          m_wrap, m_alt, m_armed, m_arm_used;
  int          m_lvl, m_lvl_g;
  bit [2:0]    m_lega, m_prev, m_ga, m_gb;
  int          m_cnt [3];

  // Observation statistics
  int max_lv, min_lv, edges, gap_cycles, any_gate;
  bit count_edges, prev_a1, seen_pa, seen_pb;

  function automatic int qsine(int i);
    longint p;
    p = longint'(i) * (512 - longint'(i));
    return int'((longint'(32767) * 16 * p) / (1310720 - 4 * p));
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model_step();
    logic [32:0] cs;
    int idx, addr, mag, tri_v, lvm, nl, ncnt;
    bit pos, t1, t3;
    bit [2:0] nlega;
    if (rst) begin
      m_lph = 0; m_cph = 0; m_wrap = 0; m_alt = 0; m_armed = 0;
      m_lvl = 0; m_lega = 0; m_prev = 0; m_ga = 0; m_gb = 0;
      m_arm_used = 0; m_lvl_g = 0;
      for (int k = 0; k < 3; k++) m_cnt[k] = 0;
    end else begin
      // decode from current phases (R1, R2)
      idx   = int'(m_lph[29:22]);
      addr  = m_lph[30] ? 255 - idx : idx;
      mag   = (int'(mod_index) * qsine(addr)) >>> 15;
      pos   = !m_lph[31];
      tri_v = m_cph[31] ? 16383 - int'(m_cph[30:17]) : int'(m_cph[30:17]);
      lvm   = ((mag > tri_v) ? 1 : 0) + ((mag > tri_v + 16384) ? 1 : 0);
      nl    = pos ? lvm : -lvm;
      t1 = (lvm == 2) || (lvm == 1 && !m_alt);
      t3 = (lvm == 2) || (lvm == 1 &&  m_alt);
      nlega[0] = t1 ? !pos : pos;
      nlega[1] = pos;
      nlega[2] = t3 ? !pos : pos;
      // dead-time stage from current requested sides (R8)
      m_arm_used = m_armed;
      m_lvl_g    = m_lvl;
      for (int k = 0; k < 3; k++) begin
        if (m_lega[k] != m_prev[k]) ncnt = int'(dead_cycles);
        else ncnt = (m_cnt[k] > 0) ? m_cnt[k] - 1 : 0;
        m_ga[k]   = m_armed &&  m_lega[k] && ncnt == 0;
        m_gb[k]   = m_armed && !m_lega[k] && ncnt == 0;
        m_cnt[k]  = ncnt;
        m_prev[k] = m_lega[k];
      end
      m_lega  = nlega;
      m_lvl   = nl;
      m_alt   = m_alt ^ m_wrap;
      m_armed = m_armed | m_wrap;
      cs      = {1'b0, m_cph} + {1'b0, carrier_step};
      m_wrap  = cs[32];
      m_cph   = cs[31:0];
      m_lph   = m_lph + line_step;
    end
  endtask

  task automatic compare();
    string tag;
    int lv;
    lv = int'($signed(level_code));
    check(lv == m_lvl, "R3", "level_code", lv, m_lvl);
    for (int k = 0; k < 3; k++) begin
      if (k == 1) tag = "R4";
      else if (!m_arm_used) tag = "R10";
      else if (m_cnt[k] != 0) tag = "R8";
      else if (m_lvl_g == 2 || m_lvl_g == -2) tag = "R5";
      else if (m_lvl_g != 0) tag = "R6";
      else tag = "R7";
      check({gate_a[k], gate_b[k]} == {m_ga[k], m_gb[k]}, tag,
            $sformatf("leg%0d gates", k + 1),
            int'({gate_a[k], gate_b[k]}), int'({m_ga[k], m_gb[k]}));
      check(!(gate_a[k] && gate_b[k]), "R9",
            $sformatf("leg%0d overlap", k + 1), int'(gate_a[k] & gate_b[k]), 0);
      if (m_arm_used && !gate_a[k] && !gate_b[k]) gap_cycles++;
    end
    if (lv > max_lv) max_lv = lv;
    if (lv < min_lv) min_lv = lv;
    if (gate_a != 0 || gate_b != 0) any_gate++;
    if (count_edges && gate_a[1] != prev_a1) edges++;
    prev_a1 = gate_a[1];
    if (gate_a[1] && gate_b[0] && gate_a[2]) seen_pa = 1;
    if (gate_a[1] && gate_a[0] && gate_b[2]) seen_pb = 1;
  endtask

  task automatic run(int n);
    repeat (n) begin
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare();
    end
  endtask

  task automatic clear_stats();
    max_lv = -9; min_lv = 9; edges = 0; gap_cycles = 0; any_gate = 0;
    seen_pa = 0; seen_pb = 0;
  endtask

  initial begin
    rst = 1; mod_index = 15'd22938; line_step = 32'd2097152;
    carrier_step = 32'd33554432; dead_cycles = 8'd3;
    count_edges = 0; prev_a1 = 0;
    clear_stats();
    run(4);
    check(gate_a == 0 && gate_b == 0, "R10", "gates in reset", int'({gate_a, gate_b}), 0);
    check(level_code == 0, "R10", "level in reset", int'(level_code), 0);
    rst = 0;
    clear_stats();
    run(129);
    check(any_gate == 0, "R10", "gate cycles before arming", any_gate, 0);
    run(1919);
    clear_stats();
    count_edges = 1;
    run(2048);
    count_edges = 0;
    check(edges == 2, "R4", "leg2 A edges per line period", edges, 2);
    check(max_lv == 2, "R1", "max level at 0.7", max_lv, 2);
    check(min_lv == -2, "R1", "min level at 0.7", min_lv, -2);

    mod_index = 15'd32767; dead_cycles = 8'd0;
    clear_stats();
    run(2048);
    check(seen_pa, "R6", "first +1 form seen", int'(seen_pa), 1);
    check(seen_pb, "R6", "second +1 form seen", int'(seen_pb), 1);

    mod_index = 15'd8000; dead_cycles = 8'd20;
    clear_stats();
    run(2048);
    check(max_lv == 1, "R2", "max level small reference", max_lv, 1);
    check(min_lv == -1, "R2", "min level small reference", min_lv, -1);
    check(gap_cycles > 0, "R8", "dead gap cycles present", gap_cycles, 1);

    mod_index = 15'd0; dead_cycles = 8'd2;
    clear_stats();
    run(2048);
    check(max_lv == 0 && min_lv == 0, "R7", "level at zero modulation", max_lv - min_lv, 0);

    rst = 1;
    run(3);
    rst = 0; line_step = 32'd2100003; carrier_step = 32'd33554467;
    mod_index = 15'd22938; dead_cycles = 8'd5;
    clear_stats();
    run(129);
    check(any_gate == 0, "R10", "gate cycles before re-arming", any_gate, 0);
    run(6000);

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule